// File: doc/BRIEF.md
# Dithered-Width Multi-Channel PWM Converter

This block turns a set of wide digital codes into pulse trains that, after an external low-pass filter, serve as slow, fine-grained DC levels. Each channel holds a code split into a coarse part and a fractional part. The coarse part sets how many clock cycles the pin stays high in each period. The fractional part feeds a first-order error accumulator that, once per period, may lengthen that period's pulse by one clock. Over many periods the mean duty then reaches the full code resolution. The pulse period stays at 2^COARSE_W clocks, not 2^(COARSE_W+FRAC_W) clocks.

All channels run from one shared free-running period counter, so every pulse starts on the same clock edge. A host writes a code to one channel at a time through a select, a code bus and a write strobe. The written code sits in a holding register and is applied only at the next period boundary, so no period is cut short or stretched by a mid-period write. With the default sizes of 14 coarse and 8 fractional bits, a 120 MHz clock gives a period rate near 7.3 kHz. A plain 16-bit counter at the same clock would give about 1.8 kHz.

Top module: `pwm_ds_dac`

## Requirements
- R1: A synchronous active-high reset clears the period counter, every held code and every residue, and drives all pins low. After reset is released, every pin stays low until a nonzero code has been written and applied.
- R2: The period is 2^COARSE_W clocks. In each period a pin is high for the first W clocks of that period and low for the rest, where W is that period's effective width. All channels start their pulses on the same clock edge.
- R3: A code written through the write strobe is held and takes effect only at the next period boundary. The period already running keeps its width.
- R4: The code is {coarse, frac}, with frac in the low FRAC_W bits. At each boundary frac is added to a FRAC_W-bit residue. The carry out adds one clock to that period's width, and the sum modulo 2^FRAC_W becomes the new residue. Over any 2^FRAC_W consecutive periods with a constant code, the total high time is 2^FRAC_W*coarse + frac clocks.
- R5: When coarse is at its maximum (2^COARSE_W-1) and a carry occurs, the width becomes 2^COARSE_W and the pin stays high for the whole period. It never wraps to zero.
- R6: Channels are independent. A write to channel k (select value k) changes only channel k's output.
- R7: A write made on the very edge of a period boundary is not used by that boundary. It takes effect at the following boundary.
- R8: A code of zero keeps the pin low for the entire period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe for the held code of the selected channel |
| wr_sel_i | input | SEL_W | Channel select for the write |
| wr_code_i | input | COARSE_W+FRAC_W | Code: coarse part in the upper bits, fraction in the lower FRAC_W bits |
| pwm_o | output | NCH | Registered pulse outputs, one per channel |

## Verification
A small configuration (3 channels, 3 coarse bits, 2 fractional bits) is swept over every one of the 32 codes on channel 0. The other channels get differently ordered codes at the same time, so crosstalk between channels shows up. Every cycle of every pin is compared against an arithmetic model of the width sequence. Four-period sums of high time per channel separate a correct carry from a missing or doubled carry, including the saturating all-high case. Writes placed mid-period and exactly on a boundary edge separate correct double-buffering from early or late application. A reset in mid-run, with live codes present, shows whether every held code and residue is cleared.

// File: rtl/pwm_ds_pkg.sv
package pwm_ds_pkg;
  // Width of a channel select; never below one bit.
  function automatic int sel_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/pwm_ds_period_ctr.sv
module pwm_ds_period_ctr #(
  parameter int COARSE_W = 14
) (
  input  logic                clk,
  input  logic                rst,
  output logic [COARSE_W-1:0] cnt,
  output logic                wrap
);
  logic [COARSE_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  assign cnt  = cnt_q;
  assign wrap = (cnt_q == {COARSE_W{1'b1}});
endmodule

// File: rtl/pwm_ds_channel.sv
module pwm_ds_channel #(
  parameter int COARSE_W = 14,
  parameter int FRAC_W   = 8,
  localparam int CODE_W  = COARSE_W + FRAC_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [CODE_W-1:0]   wr_code,
  input  logic [COARSE_W-1:0] cnt,
  input  logic                wrap,
  output logic                pwm,
  output logic [COARSE_W:0]   width
);
  logic [CODE_W-1:0]   hold_q;
  logic [FRAC_W-1:0]   res_q;
  logic [COARSE_W:0]   width_q;
  logic                pwm_q;
  logic [FRAC_W:0]     acc_sum;
  logic [COARSE_W:0]   width_nxt;

  // First-order error accumulator: carry lengthens the next period by one.
  always_comb begin
    acc_sum   = {1'b0, res_q} + {1'b0, hold_q[FRAC_W-1:0]};
    width_nxt = {1'b0, hold_q[CODE_W-1:FRAC_W]} + {{COARSE_W{1'b0}}, acc_sum[FRAC_W]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      res_q   <= '0;
      width_q <= '0;
      pwm_q   <= 1'b0;
    end else begin
      if (wr_en) hold_q <= wr_code;
      if (wrap) begin
        res_q   <= acc_sum[FRAC_W-1:0];
        width_q <= width_nxt;
      end
      pwm_q <= ({1'b0, cnt} < width_q);
    end
  end

  assign pwm   = pwm_q;
  assign width = width_q;
endmodule

// File: rtl/pwm_ds_dac.sv
module pwm_ds_dac
  import pwm_ds_pkg::*;
#(
  parameter int NCH      = 10,
  parameter int COARSE_W = 14,
  parameter int FRAC_W   = 8,
  localparam int CODE_W  = COARSE_W + FRAC_W,
  localparam int SEL_W   = sel_bits(NCH),
  localparam int WID_W   = COARSE_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [CODE_W-1:0] wr_code_i,
  output logic [NCH-1:0]    pwm_o
);
  logic [COARSE_W-1:0]  cnt_q;
  logic                 wrap_w;
  logic [NCH*WID_W-1:0] width_flat;

  pwm_ds_period_ctr #(.COARSE_W(COARSE_W)) u_ctr (
    .clk  (clk_i),
    .rst  (rst_i),
    .cnt  (cnt_q),
    .wrap (wrap_w)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic sel_hit;
    assign sel_hit = wr_en_i && (wr_sel_i == SEL_W'(g));

    pwm_ds_channel #(.COARSE_W(COARSE_W), .FRAC_W(FRAC_W)) u_ch (
      .clk     (clk_i),
      .rst     (rst_i),
      .wr_en   (sel_hit),
      .wr_code (wr_code_i),
      .cnt     (cnt_q),
      .wrap    (wrap_w),
      .pwm     (pwm_o[g]),
      .width   (width_flat[g*WID_W +: WID_W])
    );
  end
endmodule

// File: rtl/pwm_ds_chk.sv
module pwm_ds_chk #(
  parameter int NCH      = 10,
  parameter int COARSE_W = 14,
  localparam int WID_W   = COARSE_W + 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NCH-1:0]       pwm,
  input logic [COARSE_W-1:0]  cnt,
  input logic                 wrap,
  input logic [NCH*WID_W-1:0] widths
);
  localparam logic [WID_W-1:0] FULL = WID_W'(1) << COARSE_W;

  AST_RESET_LOW: assert property (@(posedge clk) rst |=> (pwm == '0)); // R1

  AST_WIDTH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(wrap) && !$past(rst)) |-> $stable(widths)); // R3

  for (genvar i = 0; i < NCH; i++) begin : g_a
    AST_ALIGNED_START: assert property (@(posedge clk) disable iff (rst)
      $rose(pwm[i]) |-> ($past(cnt) == '0)); // R2

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
      (!pwm[i] && (cnt != '0)) |=> !pwm[i]); // R2

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
      widths[i*WID_W +: WID_W] <= FULL); // R5
  end
endmodule

bind pwm_ds_dac pwm_ds_chk #(.NCH(NCH), .COARSE_W(COARSE_W)) u_chk (
  .clk    (clk_i),
  .rst    (rst_i),
  .pwm    (pwm_o),
  .cnt    (cnt_q),
  .wrap   (wrap_w),
  .widths (width_flat)
);

// File: tb/tb_pwm_ds_dac.sv
module tb_pwm_ds_dac;
  localparam int NCH = 3;
  localparam int CW  = 3;
  localparam int FW  = 2;
  localparam int CODE_W = CW + FW;
  localparam int SEL_W  = 2;
  localparam int P  = 1 << CW;
  localparam int FR = 1 << FW;
  localparam int NCODES = 1 << CODE_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [SEL_W-1:0]  wr_sel = '0;
  logic [CODE_W-1:0] wr_code = '0;
  logic [NCH-1:0] pwm;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  int n_edge = 0;
  string cur_req = "R2";
  int m_hold [NCH];
  int m_res  [NCH];
  int m_w    [NCH];
  int hi_cnt [NCH];

  always #5 clk = ~clk;

  pwm_ds_dac #(.NCH(NCH), .COARSE_W(CW), .FRAC_W(FW)) dut (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_code_i(wr_code), .pwm_o(pwm)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, n_edge);
    end
  endtask

  task automatic model_clear();
    for (int c = 0; c < NCH; c++) begin
      m_hold[c] = 0; m_res[c] = 0; m_w[c] = 0; hi_cnt[c] = 0;
    end
    n_edge = 0;
  endtask

  // Drive inputs for the next edge, let it pass, then check every pin.
  task automatic step(input bit we, input int ch, input int code);
    int pos;
    wr_en = we; wr_sel = SEL_W'(ch); wr_code = CODE_W'(code);
    @(negedge clk);
    n_edge++;
    pos = (n_edge - 1) % P;
    for (int c = 0; c < NCH; c++) begin
      bit e;
      e = (pos < m_w[c]);
      chk(pwm[c] == e, (m_w[c] == P) ? "R5" : ((m_w[c] == 0) ? "R8" : cur_req),
          int'(pwm[c]), int'(e));
      if (pwm[c]) hi_cnt[c]++;
    end
    if (n_edge % P == 0) begin
      for (int c = 0; c < NCH; c++) begin
        int s;
        s = m_res[c] + (m_hold[c] % FR);
        m_res[c] = s % FR;
        m_w[c] = (m_hold[c] / FR) + s / FR;
        if (m_w[c] > P) m_w[c] = P;
      end
    end
    if (we && ch < NCH) m_hold[ch] = code;
    wr_en = 1'b0;
  endtask

  task automatic idle_to_boundary();
    do step(0, 0, 0); while (n_edge % P != 0);
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    chk(pwm == '0, "R1", int'(pwm), 0);
    model_clear();
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R1: first periods after reset are all low
    cur_req = "R1";
    repeat (2 * P) step(0, 0, 0);
    chk(hi_cnt[0] + hi_cnt[1] + hi_cnt[2] == 0, "R1", hi_cnt[0] + hi_cnt[1] + hi_cnt[2], 0);

    // R4/R6 sweep: every code on channel 0, scrambled codes on 1 and 2
    for (int k = 0; k < NCODES; k++) begin
      int cd [NCH];
      cd[0] = k; cd[1] = (k * 7 + 3) % NCODES; cd[2] = NCODES - 1 - k;
      cur_req = "R3";
      repeat (3) step(0, 0, 0);
      for (int c = 0; c < NCH; c++) step(1, c, cd[c]);
      idle_to_boundary();
      cur_req = "R2";
      for (int c = 0; c < NCH; c++) hi_cnt[c] = 0;
      repeat (FR * P) step(0, 0, 0);
      for (int c = 0; c < NCH; c++)
        chk(hi_cnt[c] == FR * (cd[c] / FR) + cd[c] % FR, "R4 R6",
            hi_cnt[c], FR * (cd[c] / FR) + cd[c] % FR);
    end

    // R6: write only channel 1, others keep their totals
    idle_to_boundary();
    step(1, 1, 9);
    idle_to_boundary();
    for (int c = 0; c < NCH; c++) hi_cnt[c] = 0;
    repeat (FR * P) step(0, 0, 0);
    chk(hi_cnt[0] == FR * 7 + 3, "R6", hi_cnt[0], FR * 7 + 3);
    chk(hi_cnt[1] == FR * 2 + 1, "R6", hi_cnt[1], FR * 2 + 1);
    chk(hi_cnt[2] == 0, "R6", hi_cnt[2], 0);

    // R7: write exactly on a boundary edge
    cur_req = "R7";
    repeat (P - 1) step(0, 0, 0);
    step(1, 2, 24);              // this edge is a boundary
    chk(n_edge % P == 0, "R7", n_edge % P, 0);
    for (int c = 0; c < NCH; c++) hi_cnt[c] = 0;
    repeat (P) step(0, 0, 0);
    chk(hi_cnt[2] == 0, "R7", hi_cnt[2], 0);
    for (int c = 0; c < NCH; c++) hi_cnt[c] = 0;
    repeat (P) step(0, 0, 0);
    chk(hi_cnt[2] == 6, "R7", hi_cnt[2], 6);

    // R5: full-scale coarse with carry holds high all period
    step(1, 0, NCODES - 1);
    idle_to_boundary();
    for (int c = 0; c < NCH; c++) hi_cnt[c] = 0;
    repeat (FR * P) step(0, 0, 0);
    chk(hi_cnt[0] == FR * (P - 1) + FR - 1, "R5", hi_cnt[0], FR * (P - 1) + FR - 1);

    // R1: mid-run reset with live codes
    do_reset();
    cur_req = "R1";
    repeat (3 * P) step(0, 0, 0);
    chk(hi_cnt[0] + hi_cnt[1] + hi_cnt[2] == 0, "R1", hi_cnt[0] + hi_cnt[1] + hi_cnt[2], 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule